// File: doc/BRIEF.md
# Multi-Term Carry-Save Multiply-Accumulate Unit

This block adds up a fixed number of terms into one result word of `OUT_W` bits. Each term is either a lone operand or the product of its two operands. Each term carries its own flag for two's-complement interpretation and its own flag for subtraction. A small set of one-bit addends is summed in as well. The arithmetic is done modulo 2^`OUT_W`.

Internally every term expands into a fixed set of partial-product rows. A tree of 3:2 full-adder layers reduces all rows to two, and one carry-propagate adder with a carry-in resolves them. A final register presents the result one clock after the inputs are applied. Constants of weight one are placed in the free bit-0 position of each shifted carry row and in the final carry-in, so they cost no extra adder layers. These constants are the "+1" of every negated row and the one-bit addends.

Operand A of term t sits at `opa_i[t*A_W +: A_W]`, and operand B sits at `opb_i[t*B_W +: B_W]`. Bit t of each flag vector belongs to term t. The parameters set the term count, the operand widths, the output width and the number of one-bit addends. `N_BITS` must be at least 1, and `OUT_W` must be at least 2.

Top module: `mterm_mac`

## Requirements
- R1: A lone-operand term uses operand A, extended to `OUT_W` bits. The extension copies its top bit when the term's `signed_i` bit is 1 and fills with zeros when it is 0.
- R2: When a term's `sub_i` bit is 1, that term is subtracted from the total instead of added.
- R3: When a term's `is_prod_i` bit is 1 and its `signed_i` bit is 0, the term's value is the unsigned product A×B.
- R4: When a term's `is_prod_i` and `signed_i` bits are both 1, the term's value is the product of A and B, both read as two's-complement numbers. This includes the most negative values, for example A=0x80 and B=0x20 giving +4096.
- R5: Each bit of `bit_i` adds its own value (0 or 1) at weight 2^0.
- R6: The result is the exact sum of all terms and addends, reduced modulo 2^`OUT_W`. Negative totals therefore appear in two's-complement form.
- R7: When a term's `is_prod_i` bit is 0, its operand B has no effect on the result.
- R8: `sum_o` changes only at a rising clock edge. After that edge it holds the value for the inputs present at that edge.
- R9: While `rst` is 1 at a rising edge, `sum_o` becomes zero after that edge, whatever the inputs are.
- R10: When every operand and every addend bit is zero, the result is zero for any setting of the product, signed and subtract flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opa_i | input | N_TERMS*A_W | Operand A of every term, term 0 in the low bits |
| opb_i | input | N_TERMS*B_W | Operand B of every term, term 0 in the low bits |
| is_prod_i | input | N_TERMS | Per term: 1 means A×B, 0 means A alone |
| signed_i | input | N_TERMS | Per term: 1 means operands are two's-complement |
| sub_i | input | N_TERMS | Per term: 1 means the term is subtracted |
| bit_i | input | N_BITS | One-bit addends, each of weight 1 |
| sum_o | output | OUT_W | Registered sum modulo 2^OUT_W |

## Verification
The temporal properties assume two-state inputs that change only between clock edges. They also assume `rst` is high at the first edge. The hold property further assumes that the cycle before the inputs were found stable was not a reset cycle, and it guards this explicitly. The stimulus drives every input just after a falling edge, or a fixed delay after a rising edge. It starts with reset asserted, so each property's antecedent is sampled on settled values.

// File: rtl/mac_pkg.sv
package mac_pkg;

  function automatic int min_int(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // rows present at the input of reduction layer lvl, starting from n0 rows
  function automatic int rows_at(input int n0, input int lvl);
    int n;
    n = n0;
    for (int l = 0; l < lvl; l++)
      if (n > 2) n = 2 * (n / 3) + (n % 3);
    return n;
  endfunction

  // number of 3:2 layers needed to bring n0 rows down to two
  function automatic int layer_cnt(input int n0);
    int n;
    int c;
    n = n0;
    c = 0;
    for (int i = 0; i < 64; i++)
      if (n > 2) begin
        n = 2 * (n / 3) + (n % 3);
        c++;
      end
    return c;
  endfunction

  // full-adder rows consumed by all layers before lvl
  function automatic int fa_before(input int n0, input int lvl);
    int acc;
    acc = 0;
    for (int l = 0; l < lvl; l++)
      acc += rows_at(n0, l) / 3;
    return acc;
  endfunction

endpackage

// File: rtl/mac_term_rows.sv
module mac_term_rows #(
  parameter int A_W   = 8,
  parameter int B_W   = 6,
  parameter int OUT_W = 20,
  localparam int MW   = mac_pkg::max_int(A_W, B_W),
  localparam int NB   = mac_pkg::min_int(A_W, B_W),
  localparam int RT   = NB + 1
) (
  input  logic [A_W-1:0]   a_i,
  input  logic [B_W-1:0]   b_i,
  input  logic             is_prod_i,
  input  logic             sgn_i,
  input  logic             sub_i,
  output logic [OUT_W-1:0] rows_o [RT]
);

  logic [MW-1:0]    mcand;
  logic [NB-1:0]    mplier;
  logic [MW:0]      mcand_x;
  logic [A_W:0]     lone_x;
  logic [OUT_W-1:0] mcand_ext;
  logic [OUT_W-1:0] lone_ext;
  logic [OUT_W-1:0] inv_mask;
  logic [OUT_W-1:0] raw [RT];

  // the wider operand is the multiplicand, the narrower one picks rows
  if (A_W >= B_W) begin : g_a_wide
    assign mcand  = a_i;
    assign mplier = b_i;
  end else begin : g_b_wide
    assign mcand  = b_i;
    assign mplier = a_i;
  end

  assign mcand_x   = {sgn_i & mcand[MW-1], mcand};
  assign lone_x    = {sgn_i & a_i[A_W-1], a_i};
  assign mcand_ext = OUT_W'($signed(mcand_x));
  assign lone_ext  = OUT_W'($signed(lone_x));
  assign inv_mask  = {OUT_W{sub_i}};

  for (genvar j = 0; j < NB; j++) begin : g_pp
    if (j == 0 && NB == 1) begin : g_only
      always_comb begin
        if (!is_prod_i)      raw[j] = lone_ext;
        else if (!mplier[j]) raw[j] = '0;
        else if (sgn_i)      raw[j] = ~mcand_ext;
        else                 raw[j] = mcand_ext;
      end
    end else if (j == 0) begin : g_first
      always_comb begin
        if (!is_prod_i)      raw[j] = lone_ext;
        else if (!mplier[j]) raw[j] = '0;
        else                 raw[j] = mcand_ext;
      end
    end else if (j == NB - 1) begin : g_top
      // top multiplier bit carries negative weight for signed terms
      always_comb begin
        if (!is_prod_i || !mplier[j]) raw[j] = '0;
        else if (sgn_i)               raw[j] = (~mcand_ext) << j;
        else                          raw[j] = mcand_ext << j;
      end
    end else begin : g_mid
      always_comb begin
        if (!is_prod_i || !mplier[j]) raw[j] = '0;
        else                          raw[j] = mcand_ext << j;
      end
    end
  end

  // completes the two's-complement negation of the top row
  always_comb begin
    if (is_prod_i && sgn_i && mplier[NB-1]) raw[NB] = OUT_W'(1) << (NB - 1);
    else                                    raw[NB] = '0;
  end

  for (genvar j = 0; j < RT; j++) begin : g_out
    assign rows_o[j] = raw[j] ^ inv_mask;
  end

endmodule

// File: rtl/mac_fa_row.sv
module mac_fa_row #(
  parameter int W = 20
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  input  logic         fill_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] cry_o
);

  logic [W-2:0] maj;

  assign sum_o = x_i ^ y_i ^ z_i;
  assign maj   = (x_i[W-2:0] & y_i[W-2:0]) |
                 (x_i[W-2:0] & z_i[W-2:0]) |
                 (y_i[W-2:0] & z_i[W-2:0]);
  // carry shifted up one place; the vacated bit 0 takes a pending unit
  assign cry_o = {maj, fill_i};

endmodule

// File: rtl/mac_csa_tree.sv
module mac_csa_tree #(
  parameter int W      = 20,
  parameter int N_ROWS = 3
) (
  input  logic [W-1:0]      rows_i [N_ROWS],
  input  logic [N_ROWS-2:0] pend_i,
  output logic [W-1:0]      row_a_o,
  output logic [W-1:0]      row_b_o,
  output logic              cin_o
);

  localparam int LAYERS = mac_pkg::layer_cnt(N_ROWS);

  logic [W-1:0] stg [LAYERS+1][N_ROWS];

  for (genvar r = 0; r < N_ROWS; r++) begin : g_in
    assign stg[0][r] = rows_i[r];
  end

  for (genvar l = 0; l < LAYERS; l++) begin : g_lay
    localparam int NIN   = mac_pkg::rows_at(N_ROWS, l);
    localparam int NFA   = NIN / 3;
    localparam int NLEFT = NIN % 3;
    localparam int NOUT  = 2 * NFA + NLEFT;
    localparam int PBASE = mac_pkg::fa_before(N_ROWS, l);

    for (genvar k = 0; k < NFA; k++) begin : g_fa
      mac_fa_row #(.W(W)) u_fa (
        .x_i    (stg[l][3*k]),
        .y_i    (stg[l][3*k+1]),
        .z_i    (stg[l][3*k+2]),
        .fill_i (pend_i[PBASE+k]),
        .sum_o  (stg[l+1][2*k]),
        .cry_o  (stg[l+1][2*k+1])
      );
    end

    for (genvar k = 0; k < NLEFT; k++) begin : g_pass
      assign stg[l+1][2*NFA+k] = stg[l][3*NFA+k];
    end

    for (genvar k = NOUT; k < N_ROWS; k++) begin : g_idle
      assign stg[l+1][k] = '0;
    end
  end

  assign row_a_o = stg[LAYERS][0];
  assign row_b_o = stg[LAYERS][1];
  assign cin_o   = pend_i[N_ROWS-2];

endmodule

// File: rtl/mac_cpa.sv
module mac_cpa #(
  parameter int W = 20
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o
);

  assign sum_o = a_i + b_i + W'(cin_i);

endmodule

// File: rtl/mterm_mac.sv
module mterm_mac #(
  parameter int N_TERMS = 3,
  parameter int A_W     = 8,
  parameter int B_W     = 6,
  parameter int OUT_W   = 20,
  parameter int N_BITS  = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_TERMS*A_W-1:0] opa_i,
  input  logic [N_TERMS*B_W-1:0] opb_i,
  input  logic [N_TERMS-1:0]     is_prod_i,
  input  logic [N_TERMS-1:0]     signed_i,
  input  logic [N_TERMS-1:0]     sub_i,
  input  logic [N_BITS-1:0]      bit_i,
  output logic [OUT_W-1:0]       sum_o
);

  localparam int NB = mac_pkg::min_int(A_W, B_W);
  localparam int RT = NB + 1;              // rows per term
  localparam int R  = N_TERMS * RT;        // term rows
  localparam int P  = R + N_BITS;          // unit-weight bits to place
  localparam int E  = (N_BITS + 2) / 2;    // seed rows so slots suffice
  localparam int NR = R + E;               // rows entering the tree

  logic [OUT_W-1:0] rows [NR];
  logic [P-1:0]     pend_all;
  logic [NR-2:0]    pend_slot;
  logic [OUT_W-1:0] fin_a;
  logic [OUT_W-1:0] fin_b;
  logic             fin_cin;
  logic [OUT_W-1:0] sum_d;
  logic [OUT_W-1:0] sum_q;

  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    logic [OUT_W-1:0] trow [RT];

    mac_term_rows #(.A_W(A_W), .B_W(B_W), .OUT_W(OUT_W)) u_rows (
      .a_i       (opa_i[t*A_W +: A_W]),
      .b_i       (opb_i[t*B_W +: B_W]),
      .is_prod_i (is_prod_i[t]),
      .sgn_i     (signed_i[t]),
      .sub_i     (sub_i[t]),
      .rows_o    (trow)
    );

    for (genvar j = 0; j < RT; j++) begin : g_row
      assign rows[t*RT+j]     = trow[j];
      assign pend_all[t*RT+j] = sub_i[t];  // +1 owed by each inverted row
    end
  end

  for (genvar k = 0; k < N_BITS; k++) begin : g_bits
    assign pend_all[R+k] = bit_i[k];
  end

  for (genvar e = 0; e < E; e++) begin : g_seed
    assign rows[R+e] = {{(OUT_W-1){1'b0}}, pend_all[e]};
  end

  for (genvar s = 0; s < NR - 1; s++) begin : g_slot
    if (E + s < P) begin : g_used
      assign pend_slot[s] = pend_all[E+s];
    end else begin : g_zero
      assign pend_slot[s] = 1'b0;
    end
  end

  mac_csa_tree #(.W(OUT_W), .N_ROWS(NR)) u_tree (
    .rows_i  (rows),
    .pend_i  (pend_slot),
    .row_a_o (fin_a),
    .row_b_o (fin_b),
    .cin_o   (fin_cin)
  );

  mac_cpa #(.W(OUT_W)) u_cpa (
    .a_i   (fin_a),
    .b_i   (fin_b),
    .cin_i (fin_cin),
    .sum_o (sum_d)
  );

  always_ff @(posedge clk) begin
    if (rst) sum_q <= '0;
    else     sum_q <= sum_d;
  end

  assign sum_o = sum_q;

endmodule

// File: rtl/mterm_mac_chk.sv
module mterm_mac_chk #(
  parameter int N_TERMS = 3,
  parameter int A_W     = 8,
  parameter int B_W     = 6,
  parameter int OUT_W   = 20,
  parameter int N_BITS  = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic [N_TERMS*A_W-1:0] opa_i,
  input logic [N_TERMS*B_W-1:0] opb_i,
  input logic [N_TERMS-1:0]     is_prod_i,
  input logic [N_TERMS-1:0]     signed_i,
  input logic [N_TERMS-1:0]     sub_i,
  input logic [N_BITS-1:0]      bit_i,
  input logic [OUT_W-1:0]       sum_o
);

  logic rst_seen = 1'b0;

  always_ff @(posedge clk) begin
    rst_seen <= rst;
    if (rst_seen)
      p_reset_clear_r9: assert (sum_o == '0);
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(opa_i) && $stable(opb_i) && $stable(is_prod_i) &&
     $stable(signed_i) && $stable(sub_i) && $stable(bit_i)) |=> $stable(sum_o));

  p_all_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (opa_i == '0 && opb_i == '0 && bit_i == '0) |=> sum_o == '0);

  p_unit_addend_r5: assert property (@(posedge clk) disable iff (rst)
    (opa_i == '0 && opb_i == '0) |=> sum_o == OUT_W'($countones($past(bit_i))));

  p_lone_ignores_b_r7: assert property (@(posedge clk) disable iff (rst)
    (is_prod_i == '0 && opa_i == '0) |=> sum_o == OUT_W'($countones($past(bit_i))));

endmodule

bind mterm_mac mterm_mac_chk #(
  .N_TERMS(N_TERMS), .A_W(A_W), .B_W(B_W), .OUT_W(OUT_W), .N_BITS(N_BITS)
) u_chk (
  .clk(clk), .rst(rst), .opa_i(opa_i), .opb_i(opb_i), .is_prod_i(is_prod_i),
  .signed_i(signed_i), .sub_i(sub_i), .bit_i(bit_i), .sum_o(sum_o)
);

// File: tb/test_mterm_mac.sv
module test_mterm_mac;

  localparam int NT = 3;
  localparam int AW = 8;
  localparam int BW = 6;
  localparam int OW = 20;
  localparam int NBT = 2;
  localparam int NV = 10;

  // {a(24), b(18), prod(3), sgn(3), sub(3), bits(2), expected(20)}
  localparam logic [72:0] TBL [NV] = '{
    {24'h000000, 18'h00000, 3'b000, 3'b000, 3'b000, 2'b00, 20'h00000},
    {8'h00, 8'h00, 8'd200, 6'h00, 6'h00, 6'd50, 3'b001, 3'b000, 3'b000, 2'b00, 20'h02710},
    {8'h80, 8'h80, 8'hFF, 6'h00, 6'h00, 6'h3F, 3'b001, 3'b101, 3'b000, 2'b00, 20'h00001},
    {8'h00, 8'h00, 8'hFF, 6'h00, 6'h00, 6'h3F, 3'b001, 3'b000, 3'b001, 2'b11, 20'hFC141},
    {8'h7F, 8'h80, 8'h80, 6'h1F, 6'h00, 6'h20, 3'b101, 3'b111, 3'b010, 2'b00, 20'h01FE1},
    {8'h80, 8'h80, 8'h80, 6'h20, 6'h20, 6'h20, 3'b111, 3'b111, 3'b111, 2'b01, 20'hFD001},
    {8'h00, 8'h01, 8'hFF, 6'h15, 6'h2A, 6'h3F, 3'b000, 3'b000, 3'b000, 2'b00, 20'h00100},
    {8'hFF, 8'hFF, 8'hFF, 6'h3F, 6'h3F, 6'h3F, 3'b111, 3'b000, 3'b000, 2'b11, 20'h0BC45},
    {24'h000000, 18'h00000, 3'b111, 3'b111, 3'b111, 2'b00, 20'h00000},
    {8'h00, 8'h00, 8'hFF, 6'h00, 6'h00, 6'h00, 3'b000, 3'b001, 3'b000, 2'b00, 20'hFFFFF}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NT*AW-1:0]  opa = '0;
  logic [NT*BW-1:0]  opb = '0;
  logic [NT-1:0]     prod = '0;
  logic [NT-1:0]     sgn = '0;
  logic [NT-1:0]     sub = '0;
  logic [NBT-1:0]    bits = '0;
  logic [OW-1:0]     sum;
  int                n_chk = 0;
  int                n_err = 0;
  string             tags [NV];

  always #4 clk = ~clk;

  mterm_mac #(.N_TERMS(NT), .A_W(AW), .B_W(BW), .OUT_W(OW), .N_BITS(NBT)) i_mterm_mac (
    .clk(clk), .rst(rst), .opa_i(opa), .opb_i(opb), .is_prod_i(prod),
    .signed_i(sgn), .sub_i(sub), .bit_i(bits), .sum_o(sum)
  );

  function automatic logic [OW-1:0] ref_sum(input logic [NT*AW-1:0] a, input logic [NT*BW-1:0] b,
                                            input logic [NT-1:0] pr, input logic [NT-1:0] sg,
                                            input logic [NT-1:0] sb, input logic [NBT-1:0] bt);
    longint acc;
    acc = 0;
    for (int t = 0; t < NT; t++) begin
      longint av;
      longint bv;
      longint tv;
      av = sg[t] ? longint'($signed(a[t*AW +: AW])) : longint'(a[t*AW +: AW]);
      bv = sg[t] ? longint'($signed(b[t*BW +: BW])) : longint'(b[t*BW +: BW]);
      tv = pr[t] ? av * bv : av;
      acc = sb[t] ? acc - tv : acc + tv;
    end
    for (int k = 0; k < NBT; k++) acc = acc + longint'(bt[k]);
    return acc[OW-1:0];
  endfunction

  task automatic check(input logic [OW-1:0] got, input logic [OW-1:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [NT*AW-1:0] a, input logic [NT*BW-1:0] b, input logic [NT-1:0] pr,
                       input logic [NT-1:0] sg, input logic [NT-1:0] sb, input logic [NBT-1:0] bt);
    @(negedge clk);
    opa = a; opb = b; prod = pr; sgn = sg; sub = sb; bits = bt;
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    tags = '{"R10 zero", "R3 unsigned product", "R4 R1 signed mix", "R2 R5 subtract",
             "R4 most negative", "R2 all subtract", "R7 B ignored", "R3 R5 all ones",
             "R10 flags only", "R1 R6 wrap"};

    // reset state (R9)
    repeat (2) @(posedge clk);
    #2;
    check(sum, '0, "R9 reset state");
    @(negedge clk);
    rst = 1'b0;

    // table of hand-computed vectors
    for (int v = 0; v < NV; v++) begin
      drive(TBL[v][72:49], TBL[v][48:31], TBL[v][30:28], TBL[v][27:25], TBL[v][24:22], TBL[v][21:20]);
      check(sum, TBL[v][19:0], tags[v]);
    end

    // random vectors against the reference sum (R6)
    for (int i = 0; i < 300; i++) begin
      logic [NT*AW-1:0]  ra;
      logic [NT*BW-1:0]  rb;
      logic [NT-1:0]     rp;
      logic [NT-1:0]     rg;
      logic [NT-1:0]     rs;
      logic [NBT-1:0]    rt;
      ra = NT*AW'($urandom);
      rb = NT*BW'($urandom);
      rp = NT'($urandom);
      rg = NT'($urandom);
      rs = (i % 4 == 0) ? '1 : NT'($urandom);
      rt = NBT'($urandom);
      if (i % 16 == 1) ra = '1;
      if (i % 16 == 2) begin ra = {NT{8'h80}}; rb = {NT{6'h20}}; rg = '1; rp = '1; end
      drive(ra, rb, rp, rg, rs, rt);
      check(sum, ref_sum(ra, rb, rp, rg, rs, rt), "R6 random");
    end

    // B has no effect on a lone-operand term (R7)
    drive({8'h00, 8'h00, 8'h2C}, {6'h3F, 6'h3F, 6'h3F}, 3'b000, 3'b000, 3'b000, 2'b00);
    check(sum, 20'h0002C, "R7 B all ones");
    drive({8'h00, 8'h00, 8'h2C}, {6'h00, 6'h11, 6'h2A}, 3'b000, 3'b000, 3'b000, 2'b00);
    check(sum, 20'h0002C, "R7 B changed");

    // one-cycle latency and hold between edges (R8)
    drive({8'h00, 8'h00, 8'd200}, {6'h00, 6'h00, 6'd50}, 3'b001, 3'b000, 3'b000, 2'b00);
    check(sum, 20'h02710, "R8 first value");
    opa = {8'h00, 8'h00, 8'd3};
    opb = {6'h00, 6'h00, 6'd1};
    #1;
    check(sum, 20'h02710, "R8 held before edge");
    @(posedge clk);
    #2;
    check(sum, 20'h00003, "R8 updated at edge");

    // synchronous reset mid-run with active inputs (R9)
    drive({8'hFF, 8'hFF, 8'hFF}, {6'h3F, 6'h3F, 6'h3F}, 3'b111, 3'b000, 3'b000, 2'b11);
    check(sum, 20'h0BC45, "R3 before reset");
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #2;
    check(sum, '0, "R9 reset clears");
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #2;
    check(sum, 20'h0BC45, "R9 resume after reset");

    // addends only (R5)
    drive('0, '0, 3'b111, 3'b000, 3'b111, 2'b11);
    check(sum, 20'h00002, "R5 addends only");

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule